// File: doc/BRIEF.md
# Dual-Mode Programmable Watchdog Timer

This block is a hardware watchdog for a programmable logic device. Software reaches it through a small register bus (address, write data, write strobe, read strobe, registered read data). Once enabled, a down-counter runs from a programmed period. Software has to kick it through the ping register before it reaches zero. If it is not kicked in time, the watchdog takes one configured action. It can pulse a system reset, drive a fan full-speed request, or count the event in an 8-bit counter. The last two actions leave the system running.

A build-time parameter picks one of two timeout encodings. In exponent mode the timeout field is an exponent N, and the period is 2^N milliseconds with N capped at 15. In seconds mode the field is the period in whole seconds, from 1 to 255, and the remaining seconds can be read back. A prescaler built from the clock-frequency parameter makes the millisecond and second ticks. A sticky flag records that the watchdog caused a reset, and it survives the warm reset that follows.

Register map (3-bit address): 0 control, 1 timeout, 2 ping, 3 time left, 4 reset cause, 5 event count. Every other address reads zero.

Top module: `wdog_timer`

## Requirements
- R1: After power-on reset (`por_n` low), control (address 0) reads 0, reset cause (address 4) reads 0, event count (address 5) reads 0, and both action outputs are low. Timeout (address 1) reads `DEF_TMO` after the mode's clamp: 30 in seconds mode and 15 in exponent mode.
- R2: In exponent mode, a timeout field N gives an expiry exactly 2^N millisecond ticks after the counter is loaded.
- R3: In exponent mode, a timeout write above 15 is stored and read back as 15. Values from 0 to 15 are stored unchanged.
- R4: In seconds mode, the timeout field is the period in second ticks. A write of 0 is stored as 1, and 1 to 255 are stored unchanged.
- R5: Time left (address 3) reads the remaining whole seconds of the running countdown in seconds mode, and always reads 0 in exponent mode.
- R6: Writing 1 to bit 0 of the ping register (address 2) while enabled reloads the full period, restarts the prescaler and clears the fan output.
- R7: Control bit 0 is the enable. Setting it loads the full period and starts the countdown. Clearing it stops the countdown, so no action is taken, and clears the fan output.
- R8: A timeout write while enabled reloads the counter at once with the new period.
- R9: Action field control bits 3:2 = 00 (or 11): on expiry `sys_rst_o` is high for exactly `RST_CYCLES` cycles and the reset-cause flag (address 4, bit 0) is set.
- R10: The reset-cause flag survives a warm reset (`warm_rst_n` low). It is cleared only by writing 1 to address 4 bit 0 or by power-on reset. A warm reset clears control, timeout, event count and fan output.
- R11: Action field 01: on expiry `fan_full_o` goes high and stays high until a ping or enable clear. The countdown reloads and keeps running, and no reset pulse is produced.
- R12: Action field 10: each expiry adds 1 to the 8-bit event count (address 5), which wraps from 255 to 0, and the countdown keeps running.
- R13: Control bit 1 is a lock. Once set, software writes cannot clear the enable bit. Only a power-on reset clears the lock, while a warm reset clears the enable but keeps the lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| warm_rst_n | input | 1 | Synchronous warm (system) reset, active low |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe; data appears on `bus_rdata` after the next edge |
| bus_rdata | output | 8 | Registered read data |
| sys_rst_o | output | 1 | System reset pulse on expiry |
| fan_full_o | output | 1 | Fan full-speed request |

## Verification
The bound checker watches several rules on every cycle. The stored timeout always stays in its mode's legal range, and any load leaves the counter at the full period. A stopped watchdog never raises an action output. Each expiry produces the effect of its selected action one edge later, and the lock and reset-cause flag stay sticky. Some behaviour is visible only in the bench's scenarios. These are the exact expiry cycle for each period and encoding, and the reload on ping and on timeout rewrite. The rest are the pulse width, the wrap of the event counter, and the way warm and power-on resets act differently on the flags.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int DATA_W  = 8;
  localparam int ADDR_W  = 3;
  localparam int EXP_MAX = 15;
  localparam int CNT_W   = EXP_MAX + 1;

  typedef enum logic [1:0] {
    ACT_RESET = 2'b00,
    ACT_FAN   = 2'b01,
    ACT_COUNT = 2'b10,
    ACT_RSVD  = 2'b11
  } act_e;

  localparam logic [ADDR_W-1:0] A_CTRL   = 3'd0;
  localparam logic [ADDR_W-1:0] A_TMO    = 3'd1;
  localparam logic [ADDR_W-1:0] A_PING   = 3'd2;
  localparam logic [ADDR_W-1:0] A_LEFT   = 3'd3;
  localparam logic [ADDR_W-1:0] A_CAUSE  = 3'd4;
  localparam logic [ADDR_W-1:0] A_EVENTS = 3'd5;

  // Legal stored value of the timeout field for the selected encoding.
  function automatic logic [DATA_W-1:0] tmo_clamp(bit exp_mode, logic [DATA_W-1:0] v);
    if (exp_mode) begin
      return (v > DATA_W'(EXP_MAX)) ? DATA_W'(EXP_MAX) : v;
    end
    return (v == '0) ? DATA_W'(1) : v;
  endfunction

  // Number of counter units (ms or s ticks) for a stored timeout field.
  function automatic logic [CNT_W-1:0] tmo_units(bit exp_mode, logic [DATA_W-1:0] f);
    if (exp_mode) begin
      return CNT_W'(1) << f[3:0];
    end
    return CNT_W'(f);
  endfunction

  function automatic bit act_is_reset(act_e a);
    return (a == ACT_RESET) || (a == ACT_RSVD);
  endfunction
endpackage

// File: rtl/wdog_tick_gen.sv
module wdog_tick_gen #(
  parameter int unsigned CLK_HZ   = 100_000_000,
  parameter int unsigned MS_PER_S = 1000,
  parameter bit          USE_SEC  = 1'b1
) (
  input  logic clk,
  input  logic por_n,
  input  logic restart,
  output logic unit_tick_o
);
  localparam int unsigned TPM = (CLK_HZ / 1000 < 1) ? 1 : CLK_HZ / 1000;
  localparam int MW = ($clog2(TPM) < 1) ? 1 : $clog2(TPM);

  logic [MW-1:0] ms_cnt;
  logic          ms_tick;

  assign ms_tick = (ms_cnt == MW'(TPM - 1));

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      ms_cnt <= '0;
    end else if (restart || ms_tick) begin
      ms_cnt <= '0;
    end else begin
      ms_cnt <= ms_cnt + 1'b1;
    end
  end

  generate
    if (USE_SEC) begin : g_sec
      localparam int unsigned MPS = (MS_PER_S < 1) ? 1 : MS_PER_S;
      localparam int SW = ($clog2(MPS) < 1) ? 1 : $clog2(MPS);
      logic [SW-1:0] s_cnt;
      logic          s_wrap;

      assign s_wrap = (s_cnt == SW'(MPS - 1));

      always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
          s_cnt <= '0;
        end else if (restart) begin
          s_cnt <= '0;
        end else if (ms_tick) begin
          s_cnt <= s_wrap ? '0 : s_cnt + 1'b1;
        end
      end

      assign unit_tick_o = ms_tick && s_wrap;
    end else begin : g_ms
      assign unit_tick_o = ms_tick;
    end
  endgenerate
endmodule

// File: rtl/wdog_countdown.sv
module wdog_countdown #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             clr,
  input  logic             load,
  input  logic             run,
  input  logic [CNT_W-1:0] load_val,
  input  logic             tick,
  output logic [CNT_W-1:0] cnt_o,
  output logic             expire_o
);
  logic last_unit;

  assign last_unit = (cnt_o == CNT_W'(1));
  assign expire_o  = run && tick && !load && !clr && last_unit;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      cnt_o <= '0;
    end else if (clr || load || !run || expire_o) begin
      cnt_o <= load_val;
    end else if (tick) begin
      cnt_o <= cnt_o - 1'b1;
    end
  end
endmodule

// File: rtl/wdog_action.sv
module wdog_action
  import wdog_pkg::*;
#(
  parameter int RST_CYCLES = 8,
  parameter int EV_W       = 8
) (
  input  logic            clk,
  input  logic            por_n,
  input  logic            clr,
  input  logic            expire,
  input  act_e            act,
  input  logic            fan_clr,
  output logic            sys_rst_o,
  output logic            fan_full_o,
  output logic [EV_W-1:0] ev_cnt_o,
  output logic            cause_set_o
);
  localparam int PW = $clog2(RST_CYCLES + 1);

  logic [PW-1:0] rst_left;
  logic          do_rst;

  assign do_rst      = expire && act_is_reset(act);
  assign cause_set_o = do_rst;
  assign sys_rst_o   = (rst_left != '0);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      rst_left <= '0;
    end else if (do_rst) begin
      rst_left <= PW'(RST_CYCLES);
    end else if (rst_left != '0) begin
      rst_left <= rst_left - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      fan_full_o <= 1'b0;
    end else if (clr || fan_clr) begin
      fan_full_o <= 1'b0;
    end else if (expire && act == ACT_FAN) begin
      fan_full_o <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      ev_cnt_o <= '0;
    end else if (clr) begin
      ev_cnt_o <= '0;
    end else if (expire && act == ACT_COUNT) begin
      ev_cnt_o <= ev_cnt_o + 1'b1;
    end
  end
endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
  import wdog_pkg::*;
#(
  parameter int unsigned CLK_HZ     = 100_000_000,
  parameter int unsigned MS_PER_S   = 1000,
  parameter bit          EXP_MODE   = 1'b0,
  parameter logic [7:0]  DEF_TMO    = 8'd30,
  parameter int          RST_CYCLES = 8
) (
  input  logic        clk,
  input  logic        por_n,
  input  logic        warm_rst_n,
  input  logic [2:0]  bus_addr,
  input  logic [7:0]  bus_wdata,
  input  logic        bus_wr,
  input  logic        bus_rd,
  output logic [7:0]  bus_rdata,
  output logic        sys_rst_o,
  output logic        fan_full_o
);
  localparam logic [DATA_W-1:0] TMO_RST = tmo_clamp(EXP_MODE, DEF_TMO);

  logic              warm_clr;
  logic              wr_ctrl, wr_tmo, wr_ping, wr_cause;
  logic              en_q, lock_q, cause_q;
  act_e              act_q;
  logic [DATA_W-1:0] tmo_q, tmo_new;
  logic              en_next, en_rise, ping_ev, tmo_reload;
  logic              load, fan_clr, restart;
  logic [CNT_W-1:0]  load_val, cnt;
  logic              unit_tick, expire, cause_set;
  logic [DATA_W-1:0] ev_cnt, left_view, rd_mux;

  assign warm_clr   = !warm_rst_n;
  assign wr_ctrl    = bus_wr && (bus_addr == A_CTRL);
  assign wr_tmo     = bus_wr && (bus_addr == A_TMO);
  assign wr_ping    = bus_wr && (bus_addr == A_PING);
  assign wr_cause   = bus_wr && (bus_addr == A_CAUSE);

  assign tmo_new    = tmo_clamp(EXP_MODE, bus_wdata);
  assign en_next    = bus_wdata[0] || (lock_q && en_q);
  assign en_rise    = wr_ctrl && en_next && !en_q;
  assign ping_ev    = wr_ping && bus_wdata[0] && en_q;
  assign tmo_reload = wr_tmo && en_q;
  assign load       = en_rise || ping_ev || tmo_reload;
  assign load_val   = tmo_units(EXP_MODE, wr_tmo ? tmo_new : tmo_q);
  assign fan_clr    = ping_ev || (wr_ctrl && !en_next);
  assign restart    = load || warm_clr;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      en_q  <= 1'b0;
      act_q <= ACT_RESET;
      tmo_q <= TMO_RST;
    end else if (warm_clr) begin
      en_q  <= 1'b0;
      act_q <= ACT_RESET;
      tmo_q <= TMO_RST;
    end else begin
      if (wr_ctrl) begin
        en_q  <= en_next;
        act_q <= act_e'(bus_wdata[3:2]);
      end
      if (wr_tmo) begin
        tmo_q <= tmo_new;
      end
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      lock_q <= 1'b0;
    end else if (wr_ctrl && bus_wdata[1]) begin
      lock_q <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      cause_q <= 1'b0;
    end else if (cause_set) begin
      cause_q <= 1'b1;
    end else if (wr_cause && bus_wdata[0]) begin
      cause_q <= 1'b0;
    end
  end

  wdog_tick_gen #(
    .CLK_HZ  (CLK_HZ),
    .MS_PER_S(MS_PER_S),
    .USE_SEC (!EXP_MODE)
  ) u_tick (
    .clk        (clk),
    .por_n      (por_n),
    .restart    (restart),
    .unit_tick_o(unit_tick)
  );

  wdog_countdown #(
    .CNT_W(CNT_W)
  ) u_count (
    .clk     (clk),
    .por_n   (por_n),
    .clr     (warm_clr),
    .load    (load),
    .run     (en_q),
    .load_val(load_val),
    .tick    (unit_tick),
    .cnt_o   (cnt),
    .expire_o(expire)
  );

  wdog_action #(
    .RST_CYCLES(RST_CYCLES),
    .EV_W      (DATA_W)
  ) u_act (
    .clk        (clk),
    .por_n      (por_n),
    .clr        (warm_clr),
    .expire     (expire),
    .act        (act_q),
    .fan_clr    (fan_clr),
    .sys_rst_o  (sys_rst_o),
    .fan_full_o (fan_full_o),
    .ev_cnt_o   (ev_cnt),
    .cause_set_o(cause_set)
  );

  generate
    if (EXP_MODE) begin : g_left_exp
      assign left_view = '0;
    end else begin : g_left_sec
      assign left_view = (cnt > CNT_W'(255)) ? 8'hFF : cnt[7:0];
    end
  endgenerate

  always_comb begin
    unique case (bus_addr)
      A_CTRL:   rd_mux = {4'b0, act_q, lock_q, en_q};
      A_TMO:    rd_mux = tmo_q;
      A_LEFT:   rd_mux = left_view;
      A_CAUSE:  rd_mux = {7'b0, cause_q};
      A_EVENTS: rd_mux = ev_cnt;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      bus_rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/wdog_timer_chk.sv
module wdog_timer_chk #(
  parameter bit EXP_MODE = 1'b0
) (
  input logic        clk,
  input logic        por_n,
  input logic        warm_rst_n,
  input logic [2:0]  bus_addr,
  input logic [7:0]  bus_wdata,
  input logic        bus_wr,
  input logic        bus_rd,
  input logic [7:0]  bus_rdata,
  input logic        en_q,
  input logic        lock_q,
  input logic        cause_q,
  input logic [1:0]  act,
  input logic [7:0]  tmo_q,
  input logic        load,
  input logic [15:0] load_val,
  input logic [15:0] cnt,
  input logic        expire,
  input logic [7:0]  ev_cnt,
  input logic        sys_rst_o,
  input logic        fan_full_o
);
  // R3 R4
  tmo_range_chk: assert property (@(posedge clk) disable iff (!por_n)
    EXP_MODE ? (tmo_q <= 8'd15) : (tmo_q != 8'd0));

  // R6
  load_full_chk: assert property (@(posedge clk) disable iff (!por_n)
    load |=> (cnt == $past(load_val)));

  // R7
  stopped_quiet_chk: assert property (@(posedge clk) disable iff (!por_n)
    !en_q |=> (!$rose(fan_full_o) && !$rose(sys_rst_o)));

  // R9
  rst_action_chk: assert property (@(posedge clk) disable iff (!por_n)
    (expire && (act == 2'b00 || act == 2'b11)) |=> (sys_rst_o && cause_q));

  // R11
  fan_action_chk: assert property (@(posedge clk) disable iff (!por_n)
    (expire && act == 2'b01 && !bus_wr && warm_rst_n) |=> fan_full_o);

  // R12
  count_action_chk: assert property (@(posedge clk) disable iff (!por_n)
    (expire && act == 2'b10 && warm_rst_n) |=> (ev_cnt == $past(ev_cnt) + 8'd1));

  // R5
  left_zero_chk: assert property (@(posedge clk) disable iff (!por_n)
    (EXP_MODE && bus_rd && bus_addr == 3'd3) |=> (bus_rdata == 8'd0));

  // R10
  cause_sticky_chk: assert property (@(posedge clk) disable iff (!por_n)
    (cause_q && !(bus_wr && bus_addr == 3'd4 && bus_wdata[0])) |=> cause_q);

  // R13
  lock_sticky_chk: assert property (@(posedge clk) disable iff (!por_n)
    lock_q |=> lock_q);

  // R13
  lock_hold_en_chk: assert property (@(posedge clk) disable iff (!por_n)
    (lock_q && en_q && warm_rst_n) |=> en_q);
endmodule

bind wdog_timer wdog_timer_chk #(.EXP_MODE(EXP_MODE)) u_wdog_chk (
  .clk       (clk),
  .por_n     (por_n),
  .warm_rst_n(warm_rst_n),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .bus_rdata (bus_rdata),
  .en_q      (en_q),
  .lock_q    (lock_q),
  .cause_q   (cause_q),
  .act       (act_q),
  .tmo_q     (tmo_q),
  .load      (load),
  .load_val  (load_val),
  .cnt       (cnt),
  .expire    (expire),
  .ev_cnt    (ev_cnt),
  .sys_rst_o (sys_rst_o),
  .fan_full_o(fan_full_o)
);

// File: tb/test_wdog_timer.sv
`timescale 1ns/1ps
module test_wdog_timer;
  localparam int CYC_MS = 4;   // 4000 Hz clock parameter -> 4 cycles per ms tick
  localparam int CYC_S  = 32;  // 8 ms per second tick -> 32 cycles per s tick
  localparam int RSTW   = 8;

  logic clk = 1'b0;
  logic por_n = 1'b0;
  logic warm_rst_n = 1'b1;
  logic [2:0] s_addr = '0, x_addr = '0;
  logic [7:0] s_wdata = '0, x_wdata = '0;
  logic s_wr = 1'b0, x_wr = 1'b0, s_rd = 1'b0, x_rd = 1'b0;
  logic [7:0] s_rdata, x_rdata;
  logic s_rst, x_rst, s_fan, x_fan;

  int n_chk = 0;
  int n_err = 0;
  bit done_f = 1'b0;

  always #2.5 clk = ~clk;

  wdog_timer #(.CLK_HZ(4000), .MS_PER_S(8), .EXP_MODE(1'b0), .RST_CYCLES(RSTW)) i_wdog_timer (
    .clk(clk), .por_n(por_n), .warm_rst_n(warm_rst_n),
    .bus_addr(s_addr), .bus_wdata(s_wdata), .bus_wr(s_wr), .bus_rd(s_rd),
    .bus_rdata(s_rdata), .sys_rst_o(s_rst), .fan_full_o(s_fan));

  wdog_timer #(.CLK_HZ(4000), .MS_PER_S(8), .EXP_MODE(1'b1), .RST_CYCLES(RSTW)) i_wdog_timer_x (
    .clk(clk), .por_n(por_n), .warm_rst_n(warm_rst_n),
    .bus_addr(x_addr), .bus_wdata(x_wdata), .bus_wr(x_wr), .bus_rd(x_rd),
    .bus_rdata(x_rdata), .sys_rst_o(x_rst), .fan_full_o(x_fan));

  function automatic int exp_fix(int v);
    return (v > 15) ? 15 : v;
  endfunction

  function automatic int sec_fix(int v);
    return (v == 0) ? 1 : v;
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input bit dx, input logic [2:0] a, input logic [7:0] d);
    if (dx) begin x_addr = a; x_wdata = d; x_wr = 1'b1; end
    else    begin s_addr = a; s_wdata = d; s_wr = 1'b1; end
    @(negedge clk);
    x_wr = 1'b0;
    s_wr = 1'b0;
  endtask

  task automatic rd(input bit dx, input logic [2:0] a, output int d);
    if (dx) begin x_addr = a; x_rd = 1'b1; end
    else    begin s_addr = a; s_rd = 1'b1; end
    @(negedge clk);
    x_rd = 1'b0;
    s_rd = 1'b0;
    d = dx ? int'(x_rdata) : int'(s_rdata);
  endtask

  task automatic warm_pulse();
    warm_rst_n = 1'b0;
    @(negedge clk);
    warm_rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done_f) begin
      done_f = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog expired actual 0 expected 1");
    finish_run();
  end

  initial begin
    int v, r, p;
    void'($urandom(32'd4711));
    step(3);
    por_n = 1'b1;
    step(1);

    // R1 reset state
    rd(0, 3'd0, r); check("R1 ctrl", r, 0);
    rd(0, 3'd1, r); check("R1 sec timeout", r, 30);
    rd(1, 3'd1, r); check("R1 exp timeout", r, 15);
    rd(0, 3'd4, r); check("R1 cause", r, 0);
    rd(0, 3'd5, r); check("R1 events", r, 0);
    check("R1 outputs", int'({s_rst, s_fan, x_rst, x_fan}), 0);

    // R3 R4 random timeout writes and readback
    for (int i = 0; i < 24; i++) begin
      v = int'($urandom_range(0, 255));
      wr(0, 3'd1, 8'(v)); rd(0, 3'd1, r); check("R4 sec clamp", r, sec_fix(v));
      v = int'($urandom_range(0, 255));
      wr(1, 3'd1, 8'(v)); rd(1, 3'd1, r); check("R3 exp clamp", r, exp_fix(v));
    end
    wr(0, 3'd1, 8'd0);  rd(0, 3'd1, r); check("R4 zero to one", r, 1);
    wr(1, 3'd1, 8'd16); rd(1, 3'd1, r); check("R3 16 saturates", r, 15);
    wr(1, 3'd1, 8'd15); rd(1, 3'd1, r); check("R3 15 kept", r, 15);

    // R5 time left: exponent mode reads zero
    wr(1, 3'd1, 8'd5); wr(1, 3'd0, 8'd9);
    step(10);
    rd(1, 3'd3, r); check("R5 exp left zero", r, 0);
    wr(1, 3'd0, 8'd0);

    // R5 seconds mode remaining time
    wr(0, 3'd1, 8'd6); wr(0, 3'd0, 8'd9);
    rd(0, 3'd3, r); check("R5 sec left start", r, 6);
    step(2 * CYC_S + 5);
    rd(0, 3'd3, r); check("R5 sec left later", r, 4);
    wr(0, 3'd0, 8'd0);

    // R4 R11 fan action, two second period
    wr(0, 3'd1, 8'd2); wr(0, 3'd0, 8'd5);
    step(2 * CYC_S - 1); check("R4 before expiry", s_fan, 0);
    step(1);             check("R11 fan on expiry", s_fan, 1);
    step(40);            check("R11 fan held", s_fan, 1);
    check("R11 no reset pulse", s_rst, 0);

    // R6 ping clears fan and reloads
    wr(0, 3'd2, 8'd1);   check("R6 ping clears fan", s_fan, 0);
    step(2 * CYC_S - 1); check("R6 reload before", s_fan, 0);
    step(1);             check("R6 reload expiry", s_fan, 1);
    wr(0, 3'd2, 8'd1);
    step(50);
    wr(0, 3'd2, 8'd1);
    step(2 * CYC_S - 1); check("R6 mid ping before", s_fan, 0);
    step(1);             check("R6 mid ping expiry", s_fan, 1);
    wr(0, 3'd0, 8'd0);   check("R7 disable clears fan", s_fan, 0);

    // R8 timeout rewrite while running
    wr(0, 3'd1, 8'd3); wr(0, 3'd0, 8'd5);
    step(40);
    wr(0, 3'd1, 8'd1);
    step(CYC_S - 1); check("R8 new period before", s_fan, 0);
    step(1);         check("R8 new period expiry", s_fan, 1);
    wr(0, 3'd0, 8'd0);

    // R7 stop and restart
    wr(0, 3'd0, 8'd5);
    step(20);
    wr(0, 3'd0, 8'd4);
    step(100);       check("R7 stopped no action", s_fan, 0);
    wr(0, 3'd0, 8'd5);
    step(CYC_S - 1); check("R7 restart before", s_fan, 0);
    step(1);         check("R7 restart full period", s_fan, 1);
    wr(0, 3'd0, 8'd0);

    // R2 exponent periods
    for (int n = 0; n < 5; n++) begin
      p = CYC_MS << n;
      wr(1, 3'd1, 8'(n)); wr(1, 3'd0, 8'd5);
      step(p - 1); check("R2 before expiry", x_fan, 0);
      step(1);     check("R2 expiry", x_fan, 1);
      wr(1, 3'd0, 8'd0);
    end

    // R12 event counting and wrap
    wr(1, 3'd1, 8'd0);
    wr(1, 3'd0, 8'd9); step(37);  wr(1, 3'd0, 8'd0);
    rd(1, 3'd5, r); check("R12 nine events", r, 9);
    wr(1, 3'd0, 8'd9); step(988); wr(1, 3'd0, 8'd0);
    rd(1, 3'd5, r); check("R12 wrap to zero", r, 0);
    wr(1, 3'd0, 8'd9); step(8);   wr(1, 3'd0, 8'd0);
    rd(1, 3'd5, r); check("R12 after wrap", r, 2);
    check("R12 no reset pulse", x_rst, 0);

    // R9 reset action pulse and cause flag
    wr(1, 3'd1, 8'd2); wr(1, 3'd0, 8'd1);
    step(4 * CYC_MS - 1); check("R9 before expiry", x_rst, 0);
    step(1);              check("R9 pulse start", x_rst, 1);
    step(RSTW - 1);       check("R9 pulse last", x_rst, 1);
    step(1);              check("R9 pulse end", x_rst, 0);
    wr(1, 3'd0, 8'd0);
    rd(1, 3'd4, r); check("R9 cause set", r, 1);

    // R10 cause flag survives warm reset, clears on write 1
    rd(1, 3'd5, r); check("R10 events before warm", r, 2);
    warm_pulse();
    rd(1, 3'd4, r); check("R10 cause after warm", r, 1);
    rd(1, 3'd5, r); check("R10 events cleared", r, 0);
    rd(1, 3'd1, r); check("R10 timeout default", r, 15);
    wr(1, 3'd4, 8'd0); rd(1, 3'd4, r); check("R10 write 0 keeps", r, 1);
    wr(1, 3'd4, 8'd1); rd(1, 3'd4, r); check("R10 write 1 clears", r, 0);
    wr(1, 3'd1, 8'd0); wr(1, 3'd0, 8'd1);
    step(10);
    wr(1, 3'd0, 8'd0);
    rd(1, 3'd4, r); check("R10 cause set again", r, 1);

    // R13 lock
    wr(0, 3'd1, 8'd1); wr(0, 3'd0, 8'd7);
    wr(0, 3'd0, 8'd4);
    rd(0, 3'd0, r); check("R13 enable held", r, 7);
    warm_pulse();
    rd(0, 3'd0, r); check("R13 lock after warm", r, 2);
    por_n = 1'b0;
    step(2);
    por_n = 1'b1;
    step(1);
    rd(0, 3'd0, r); check("R13 lock cleared by POR", r, 0);
    rd(1, 3'd4, r); check("R10 cause cleared by POR", r, 0);

    finish_run();
  end
endmodule